// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side control logic for a legacy plug-and-play expansion card. The host first writes a register index to an index port. It then writes data to, or reads data from, the register at that index. The block tracks which of four states the card is in: waiting for the initiation key, sleeping, isolating or configuring. It stores the card select number, the selected logical device, and an activate bit and range-check controls for each logical device.

A wake command names a card select number. A sleeping card whose number matches moves to isolation when the data is zero and to configuration otherwise. A matching wake also rewinds the pointer into the resource-byte stream. The configuration-control register resets the devices, sends the card back to wait for the key, or clears the select number. Resource bytes come from an outside source addressed by the pointer. The source reports when a byte is ready, and each read of the resource register takes that byte and moves the pointer on. While a device's range check is enabled and the device is inactive, host reads that hit the device's I/O range are answered with a fixed pattern.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After synchronous reset the card state is wait-for-key (code 0), the select number reads 0x00, every device is inactive with range check off, and `io_drive` is low.
- R2: State codes on `card_state` are 0 wait-for-key, 1 sleep, 2 isolation and 3 config. In wait-for-key, data writes are ignored and reads still return data. A one-cycle `key_seen` pulse moves the card to sleep, and `key_seen` has no effect in any other state.
- R3: A write of index 0x03 while in sleep, with data equal to the select number, moves the card to isolation (data 0x00) or to config (data nonzero) and sets `res_ptr` to 0. A write whose data does not match leaves the state unchanged.
- R4: Index 0x06 holds the select number. It can be read in any state and written in sleep, isolation or config.
- R5: A write to index 0x02 acts on its bits. Bit 0 returns every device's activate and range-check bits to zero and keeps the select number and the state. Bit 1 returns the card to wait-for-key and keeps the select number and the device registers. Bit 2 clears the select number. A read of index 0x02 returns 0x00.
- R6: Index 0x07 selects the logical device and can be written only in config. Values of NUM_DEV or more are ignored. A single-device build reads 0x00 here.
- R7: Index 0x30 bit 0 is the activate bit of the selected device, and bits 7:1 read zero. It can be written only in config. A write is ignored while that device's range check is enabled, and the bit reads zero during the check.
- R8: Index 0x31 holds range-check enable in bit 1 and pattern select in bit 0 for the selected device, written in config. Bits 7:2 read zero.
- R9: One cycle after an `io_hit` bit is high for a device that has range check enabled and is inactive, `io_drive` is high and `io_data` is 0x55 (pattern bit set) or 0xAA (pattern bit clear). The lowest-numbered such device wins. Otherwise `io_drive` is low.
- R10: Index 0x05 reads `{7'b0, res_valid}`. A read of index 0x04 returns `res_byte` and increments `res_ptr` when `res_valid` is high. When `res_valid` is low it returns 0x00 and the pointer does not move.
- R11: Read data appears on `bus_rdata` the cycle after `bus_rd`. Indices with no readable register, including 0x03, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_seen | input | 1 | One-cycle strobe from the initiation-key detector |
| bus_idx_we | input | 1 | Load `bus_wdata` into the index register |
| bus_wr | input | 1 | Write `bus_wdata` to the indexed register |
| bus_rd | input | 1 | Read the indexed register |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| res_valid | input | 1 | Resource source has a byte ready |
| res_byte | input | 8 | Resource byte at `res_ptr` |
| res_ptr | output | PTR_W | Resource stream pointer |
| io_hit | input | NUM_DEV | Host read hits that device's assigned I/O range |
| io_drive | output | 1 | Range-check response valid |
| io_data | output | 8 | Range-check response pattern |
| card_state | output | 2 | Card state code |

## Verification
A wrong card state shows up within one cycle on `card_state`. It shows up two cycles later in the select-number readback, because a write that was wrongly ignored or wrongly accepted changes what index 0x06 returns. A bad pointer shows up at once on `res_ptr`, and on the next resource read it returns the wrong byte. Corrupted device bits show up in the 0x30 and 0x31 readbacks. They also show up one cycle after an `io_hit`, as a wrong `io_drive` or pattern.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOL     = 2'd2,
    ST_CONFIG   = 2'd3
  } card_st_e;

  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_RES    = 8'h04;
  localparam logic [7:0] IDX_STAT   = 8'h05;
  localparam logic [7:0] IDX_CSN    = 8'h06;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_RCHK   = 8'h31;

  localparam logic [7:0] PAT_SET    = 8'h55;
  localparam logic [7:0] PAT_CLR    = 8'hAA;
endpackage

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_cfg_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_seen,
  input  logic             wr_ev,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  input  logic             res_adv,
  output card_st_e         state,
  output logic [7:0]       csn,
  output logic [PTR_W-1:0] ptr,
  output logic             dev_clr
);
  logic live_wr;
  logic wake_hit;

  assign live_wr  = wr_ev && (state != ST_WAIT_KEY);
  assign wake_hit = live_wr && (idx == IDX_WAKE) && (state == ST_SLEEP) && (wdata == csn);
  assign dev_clr  = live_wr && (idx == IDX_CTRL) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT_KEY;
      csn   <= '0;
      ptr   <= '0;
    end else begin
      if (state == ST_WAIT_KEY && key_seen) state <= ST_SLEEP;
      if (res_adv) ptr <= ptr + 1'b1;
      if (live_wr) begin
        case (idx)
          IDX_CTRL: begin
            if (wdata[1]) state <= ST_WAIT_KEY;
            if (wdata[2]) csn   <= '0;
          end
          IDX_CSN: csn <= wdata;
          default: ;
        endcase
      end
      if (wake_hit) begin
        state <= (wdata == 8'h00) ? ST_ISOL : ST_CONFIG;
        ptr   <= '0;
      end
    end
  end

  assert_key_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_KEY && !key_seen) |=> (state == ST_WAIT_KEY));
  assert_waitkey_csn_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_KEY) |=> $stable(csn));
  assert_wake_isol_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && idx == IDX_WAKE && state == ST_SLEEP && wdata == csn && wdata == 8'h00)
    |=> (state == ST_ISOL));
  assert_wake_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && idx == IDX_WAKE && state == ST_SLEEP && wdata == csn) |=> (ptr == '0));
  assert_ctrl_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && state != ST_WAIT_KEY && idx == IDX_CTRL && wdata[1]) |=> (state == ST_WAIT_KEY));
endmodule

// File: rtl/pnp_ldev_regs.sv
module pnp_ldev_regs
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int LDN_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  input  logic               dev_clr,
  output logic [LDN_W-1:0]   ldn,
  output logic [NUM_DEV-1:0] act,
  output logic [NUM_DEV-1:0] rc_en,
  output logic [NUM_DEV-1:0] rc55
);
  generate
    if (NUM_DEV > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) ldn <= '0;
        else if (cfg_wr && idx == IDX_LDN && int'(wdata) < NUM_DEV)
          ldn <= wdata[LDN_W-1:0];
      end
    end else begin : g_single
      assign ldn = '0;
    end
  endgenerate

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic sel;
    assign sel = (int'(ldn) == d);

    always_ff @(posedge clk) begin
      if (rst || dev_clr) begin
        act[d]   <= 1'b0;
        rc_en[d] <= 1'b0;
        rc55[d]  <= 1'b0;
      end else if (cfg_wr && sel) begin
        if (idx == IDX_ACT && !rc_en[d]) act[d] <= wdata[0];
        if (idx == IDX_RCHK) begin
          rc_en[d] <= wdata[1];
          rc55[d]  <= wdata[0];
        end
      end
    end

    assert_act_locked_R7: assert property (@(posedge clk) disable iff (rst)
      (rc_en[d] && cfg_wr && idx == IDX_ACT) |=> $stable(act[d]));
    assert_devclr_R5: assert property (@(posedge clk) disable iff (rst)
      dev_clr |=> (!act[d] && !rc_en[d]));
  end
endmodule

// File: rtl/pnp_range_resp.sv
module pnp_range_resp
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] io_hit,
  input  logic [NUM_DEV-1:0] act,
  input  logic [NUM_DEV-1:0] rc_en,
  input  logic [NUM_DEV-1:0] rc55,
  output logic               io_drive,
  output logic [7:0]         io_data
);
  logic       any_hit;
  logic [7:0] pat;

  always_comb begin
    any_hit = 1'b0;
    pat     = 8'h00;
    for (int d = NUM_DEV - 1; d >= 0; d--) begin
      if (io_hit[d] && rc_en[d] && !act[d]) begin
        any_hit = 1'b1;
        pat     = rc55[d] ? PAT_SET : PAT_CLR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_drive <= 1'b0;
      io_data  <= 8'h00;
    end else begin
      io_drive <= any_hit;
      io_data  <= any_hit ? pat : 8'h00;
    end
  end

  assert_pattern_R9: assert property (@(posedge clk) disable iff (rst)
    io_drive |-> (io_data == PAT_SET || io_data == PAT_CLR));
  assert_drive_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (io_hit == '0) |=> !io_drive);
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int PTR_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_seen,
  input  logic               bus_idx_we,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               res_valid,
  input  logic [7:0]         res_byte,
  output logic [PTR_W-1:0]   res_ptr,
  input  logic [NUM_DEV-1:0] io_hit,
  output logic               io_drive,
  output logic [7:0]         io_data,
  output logic [1:0]         card_state
);
  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0]         idx_q;
  card_st_e           state;
  logic [7:0]         csn;
  logic               dev_clr;
  logic               res_adv;
  logic [LDN_W-1:0]   ldn;
  logic [NUM_DEV-1:0] act, rc_en, rc55;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (bus_idx_we) idx_q <= bus_wdata;
  end

  assign res_adv = bus_rd && idx_q == IDX_RES && res_valid;

  pnp_card_fsm #(.PTR_W(PTR_W)) fsm_i (
    .clk(clk), .rst(rst), .key_seen(key_seen), .wr_ev(bus_wr),
    .idx(idx_q), .wdata(bus_wdata), .res_adv(res_adv),
    .state(state), .csn(csn), .ptr(res_ptr), .dev_clr(dev_clr)
  );

  pnp_ldev_regs #(.NUM_DEV(NUM_DEV), .LDN_W(LDN_W)) ldev_i (
    .clk(clk), .rst(rst), .cfg_wr(bus_wr && state == ST_CONFIG),
    .idx(idx_q), .wdata(bus_wdata), .dev_clr(dev_clr),
    .ldn(ldn), .act(act), .rc_en(rc_en), .rc55(rc55)
  );

  pnp_range_resp #(.NUM_DEV(NUM_DEV)) resp_i (
    .clk(clk), .rst(rst), .io_hit(io_hit), .act(act), .rc_en(rc_en),
    .rc55(rc55), .io_drive(io_drive), .io_data(io_data)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else if (bus_rd) begin
      case (idx_q)
        IDX_RES:  bus_rdata <= res_valid ? res_byte : 8'h00;
        IDX_STAT: bus_rdata <= {7'b0, res_valid};
        IDX_CSN:  bus_rdata <= csn;
        IDX_LDN:  bus_rdata <= 8'(ldn);
        IDX_ACT:  bus_rdata <= {7'b0, act[ldn] && !rc_en[ldn]};
        IDX_RCHK: bus_rdata <= {6'b0, rc_en[ldn], rc55[ldn]};
        default:  bus_rdata <= 8'h00;
      endcase
    end
  end

  assign card_state = state;

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx_q == IDX_RES && !res_valid && !bus_wr) |=> $stable(res_ptr));
  assert_act_read_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx_q == IDX_ACT) |=> (bus_rdata[7:1] == 7'b0));
endmodule

// File: tb/pnp_card_ctrl_tb.sv
module pnp_card_ctrl_tb_top;
  localparam int NUM_DEV = 2;
  localparam int PTR_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_seen = 0, bus_idx_we = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic res_valid = 1'b1;
  logic [7:0] res_byte;
  logic [PTR_W-1:0] res_ptr;
  logic [NUM_DEV-1:0] io_hit = '0;
  logic io_drive;
  logic [7:0] io_data;
  logic [1:0] card_state;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign res_byte = 8'(res_ptr) ^ 8'h5A;

  pnp_card_ctrl #(.NUM_DEV(NUM_DEV), .PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst(rst), .key_seen(key_seen), .bus_idx_we(bus_idx_we),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .res_valid(res_valid), .res_byte(res_byte), .res_ptr(res_ptr),
    .io_hit(io_hit), .io_drive(io_drive), .io_data(io_data), .card_state(card_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); bus_idx_we = 1; bus_wdata = i;
    @(negedge clk); bus_idx_we = 0; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
    @(negedge clk); bus_idx_we = 1; bus_wdata = i;
    @(negedge clk); bus_idx_we = 0; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse_key();
    @(negedge clk); key_seen = 1;
    @(negedge clk); key_seen = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 state", card_state, 0);
    check("R1 io_drive", io_drive, 0);
    rd_reg(8'h06, d); check("R1 csn", d, 0);
    rd_reg(8'h30, d); check("R1 act", d, 0);
  endtask

  task automatic t_waitkey();
    logic [7:0] d;
    wr_reg(8'h06, 8'h05);
    rd_reg(8'h06, d); check("R2 write ignored in wait-key", d, 0);
    check("R2 still wait-key", card_state, 0);
    pulse_key();
    check("R2 key to sleep", card_state, 1);
    pulse_key();
    check("R2 key ignored in sleep", card_state, 1);
  endtask

  task automatic t_wake_isol();
    logic [7:0] d;
    wr_reg(8'h03, 8'h01);
    check("R3 non-matching wake", card_state, 1);
    wr_reg(8'h03, 8'h00);
    check("R3 wake zero to isolation", card_state, 2);
    wr_reg(8'h06, 8'h03);
    rd_reg(8'h06, d); check("R4 csn write in isolation", d, 3);
  endtask

  task automatic t_cfgctrl_wait();
    logic [7:0] d;
    wr_reg(8'h02, 8'h02);
    check("R5 bit1 to wait-key", card_state, 0);
    rd_reg(8'h06, d); check("R5 bit1 keeps csn", d, 3);
    rd_reg(8'h02, d); check("R5 ctrl reads zero", d, 0);
  endtask

  task automatic t_wake_config();
    logic [7:0] d;
    pulse_key();
    rd_reg(8'h04, d); check("R10 first byte", d, 8'h5A);
    rd_reg(8'h04, d); check("R10 second byte", d, 8'h5B);
    check("R10 ptr advanced", res_ptr, 2);
    wr_reg(8'h03, 8'h05);
    check("R3 mismatch stays sleep", card_state, 1);
    check("R3 mismatch keeps ptr", res_ptr, 2);
    wr_reg(8'h03, 8'h03);
    check("R3 wake nonzero to config", card_state, 3);
    check("R3 wake rewinds ptr", res_ptr, 0);
  endtask

  task automatic t_resource();
    logic [7:0] d;
    rd_reg(8'h05, d); check("R10 status ready", d, 1);
    rd_reg(8'h04, d); check("R10 byte after rewind", d, 8'h5A);
    res_valid = 0;
    rd_reg(8'h05, d); check("R10 status not ready", d, 0);
    rd_reg(8'h04, d); check("R10 byte when not ready", d, 0);
    check("R10 ptr held", res_ptr, 1);
    res_valid = 1;
  endtask

  task automatic t_ldev();
    logic [7:0] d;
    wr_reg(8'h07, 8'h01);
    rd_reg(8'h07, d); check("R6 ldn write", d, 1);
    wr_reg(8'h07, 8'h02);
    rd_reg(8'h07, d); check("R6 out-of-range ldn ignored", d, 1);
    wr_reg(8'h30, 8'hFF);
    rd_reg(8'h30, d); check("R7 activate dev1", d, 1);
    wr_reg(8'h07, 8'h00);
    rd_reg(8'h30, d); check("R7 dev0 unaffected", d, 0);
  endtask

  task automatic t_rangecheck();
    logic [7:0] d;
    wr_reg(8'h31, 8'hFF);
    rd_reg(8'h31, d); check("R8 readback", d, 3);
    @(negedge clk); io_hit = 2'b01;
    @(negedge clk); io_hit = 2'b00;
    check("R9 drive 0x55", io_drive, 1);
    check("R9 data 0x55", io_data, 8'h55);
    wr_reg(8'h31, 8'h02);
    @(negedge clk); io_hit = 2'b11;
    @(negedge clk); io_hit = 2'b00;
    check("R9 data 0xAA", io_data, 8'hAA);
    @(negedge clk); io_hit = 2'b10;
    @(negedge clk); io_hit = 2'b00;
    check("R9 no drive for dev1", io_drive, 0);
    wr_reg(8'h30, 8'h01);
    rd_reg(8'h30, d); check("R7 write ignored during check", d, 0);
    wr_reg(8'h31, 8'h00);
    rd_reg(8'h30, d); check("R7 still inactive", d, 0);
    wr_reg(8'h30, 8'h01);
    rd_reg(8'h30, d); check("R7 activate after check off", d, 1);
    wr_reg(8'h31, 8'h03);
    rd_reg(8'h30, d); check("R7 masked during check", d, 0);
    @(negedge clk); io_hit = 2'b01;
    @(negedge clk); io_hit = 2'b00;
    check("R9 no drive when active", io_drive, 0);
  endtask

  task automatic t_devreset();
    logic [7:0] d;
    wr_reg(8'h02, 8'h01);
    rd_reg(8'h31, d); check("R5 bit0 clears range check", d, 0);
    wr_reg(8'h07, 8'h01);
    rd_reg(8'h30, d); check("R5 bit0 clears activate", d, 0);
    rd_reg(8'h06, d); check("R5 bit0 keeps csn", d, 3);
    check("R5 bit0 keeps state", card_state, 3);
    wr_reg(8'h02, 8'h04);
    rd_reg(8'h06, d); check("R5 bit2 clears csn", d, 0);
  endtask

  task automatic t_undef();
    logic [7:0] d;
    rd_reg(8'h10, d); check("R11 undefined index", d, 0);
    rd_reg(8'h03, d); check("R11 wake reads zero", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_waitkey();
    t_wake_isol();
    t_cfgctrl_wait();
    t_wake_config();
    t_resource();
    t_ldev();
    t_rangecheck();
    t_devreset();
    t_undef();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule